// File: doc/BRIEF.md
# Byte SPI Master with Routable Chip Select

This peripheral sits on a small processor register bus and runs one eight-bit SPI exchange at a time. Software loads a byte to send and picks which of four general-purpose output pins should act as chip select. It then sets the start bit in the control register. The engine shifts the byte out on MOSI, captures MISO into a separate receive register, and raises a completion flag that software polls.

The four output pins normally show the contents of a general output register. A pin claimed as chip select carries the active-low select level instead, so software can reach several SPI devices without any dedicated select pin. The serial clock is the system clock divided by the even parameter `CLK_DIV`. The bus is eight bits wide. A write lands on the rising clock edge when `bus_we` is high, and `bus_rdata` is a combinational decode of `bus_addr`.

Top module: `spi_route_master`

## Requirements
- R1: After reset, `out_pins` is 0, `spi_sclk` is low, the status register reads 0 and the receive register (offset 12) reads 0.
- R2: Register offsets behave as follows. Offset 0 holds the general output value in bits 3:0 (read/write). Offset 8 holds the transmit byte (read/write). Offset 12 holds the receive byte and ignores writes. Offset 5 reads the latched one-hot pin selection in bits 4:1 and a busy flag in bit 0.
- R3: The transfer uses SPI mode 0 with the most significant bit first. MOSI shows bit 7 as soon as the select asserts. It changes only in the cycle in which `spi_sclk` falls.
- R4: Each transfer gives exactly eight rising SCLK edges, spaced `CLK_DIV` system clocks apart. SCLK stays low whenever no transfer runs.
- R5: The claimed select pin goes low `CLK_DIV/2` cycles before the first rising SCLK edge. It returns high `CLK_DIV/2` cycles after the last falling edge, which is `CLK_DIV` cycles after the eighth rising edge.
- R6: Status bit 0 reads 1 once a transfer has finished. It reads 0 from the cycle after an accepted start.
- R7: The receive register holds the eight MISO values sampled at the rising edges, the first sample in bit 7.
- R8: A control write with bit 0 set starts a transfer. Bits 4:1 choose pins 0 to 3 as select. If several of those bits are set, only the lowest-numbered one takes effect.
- R9: The selected pin shows the select level: low during a transfer and high otherwise, whatever its general output bit holds. Unselected pins show their general output bits.
- R10: While a transfer runs, control writes are ignored entirely. There is no new start and no change of selection.
- R11: A transfer started with no selection bits set still runs its eight clocks, and all four pins keep showing the general output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| spi_miso | input | 1 | Serial data from the device |
| spi_mosi | output | 1 | Serial data to the device |
| spi_sclk | output | 1 | Serial clock |
| out_pins | output | 4 | General outputs, one of which may carry chip select |

## Verification
The hardest case to reach is a control write that arrives in the middle of a shift. It must neither restart the engine nor move the select onto another pin. The bench reaches it by issuing a bus write partway through the sample loop of a running transfer. The write requests a new start on a different pin. The bench then confirms three things: exactly eight clock edges, the newly named pin still following its general output bit, and an unchanged selection on readback. The bench also models the device side. It moves MISO after every falling SCLK edge, so the receive byte is checked against a pattern the device itself shifted out.

// File: rtl/spi_route_pkg.sv
package spi_route_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_HIGH  = 3'd2,
    ST_LOW   = 3'd3,
    ST_TRAIL = 3'd4
  } xfer_st_t;

  localparam int OFS_GPO  = 0;
  localparam int OFS_CTRL = 5;
  localparam int OFS_STAT = 6;
  localparam int OFS_TX   = 8;
  localparam int OFS_RX   = 12;

endpackage

// File: rtl/spi_route_clkdiv.sv
module spi_route_clkdiv #(
  parameter int HALF_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_n;

  assign tick = run && (cnt_q == CW'(HALF_CYC - 1));

  always_comb begin
    cnt_n = cnt_q;
    if (!run)      cnt_n = '0;
    else if (tick) cnt_n = '0;
    else           cnt_n = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_route_engine.sv
module spi_route_engine
  import spi_route_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_byte,
  input  logic              miso,
  input  logic              tick,
  output logic              busy,
  output logic              cs_act,
  output logic              sclk,
  output logic              mosi,
  output logic              done_pulse,
  output logic [DATA_W-1:0] rx_byte
);
  localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;

  xfer_st_t          st_q, st_n;
  logic [DATA_W-1:0] sh_q, sh_n;
  logic [DATA_W-1:0] rs_q, rs_n;
  logic [DATA_W-1:0] rx_q, rx_n;
  logic [BCW-1:0]    bc_q, bc_n;
  logic              sclk_q, cs_q;

  always_comb begin
    st_n       = st_q;
    sh_n       = sh_q;
    rs_n       = rs_q;
    rx_n       = rx_q;
    bc_n       = bc_q;
    done_pulse = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start) begin
          st_n = ST_LEAD;
          sh_n = tx_byte;
          bc_n = '0;
        end
      end
      ST_LEAD: begin
        if (tick) begin
          st_n = ST_HIGH;
          rs_n = {rs_q[DATA_W-2:0], miso};
        end
      end
      ST_HIGH: begin
        if (tick) begin
          if (bc_q == BCW'(DATA_W - 1)) begin
            st_n = ST_TRAIL;
          end else begin
            st_n = ST_LOW;
            sh_n = {sh_q[DATA_W-2:0], 1'b0};
            bc_n = bc_q + 1'b1;
          end
        end
      end
      ST_LOW: begin
        if (tick) begin
          st_n = ST_HIGH;
          rs_n = {rs_q[DATA_W-2:0], miso};
        end
      end
      ST_TRAIL: begin
        if (tick) begin
          st_n       = ST_IDLE;
          rx_n       = rs_q;
          done_pulse = 1'b1;
        end
      end
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      sh_q   <= '0;
      rs_q   <= '0;
      rx_q   <= '0;
      bc_q   <= '0;
      sclk_q <= 1'b0;
      cs_q   <= 1'b0;
    end else begin
      st_q   <= st_n;
      sh_q   <= sh_n;
      rs_q   <= rs_n;
      rx_q   <= rx_n;
      bc_q   <= bc_n;
      sclk_q <= (st_n == ST_HIGH);
      cs_q   <= (st_n != ST_IDLE);
    end
  end

  assign busy    = (st_q != ST_IDLE);
  assign cs_act  = cs_q;
  assign sclk    = sclk_q;
  assign mosi    = sh_q[DATA_W-1];
  assign rx_byte = rx_q;
endmodule

// File: rtl/spi_route_regs.sv
module spi_route_regs
  import spi_route_pkg::*;
#(
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               busy,
  input  logic               done_pulse,
  input  logic [DATA_W-1:0]  rx_byte,
  output logic [NUM_OUT-1:0] gpo,
  output logic [NUM_OUT-1:0] csel,
  output logic [DATA_W-1:0]  tx_byte,
  output logic               start,
  output logic               ctrl_wr,
  output logic               done_flag
);
  logic [NUM_OUT-1:0] gpo_q, gpo_n;
  logic [NUM_OUT-1:0] csel_q, csel_n;
  logic [DATA_W-1:0]  tx_q, tx_n;
  logic               done_q, done_n;
  logic [NUM_OUT-1:0] req_bits;
  logic [NUM_OUT-1:0] pick;
  logic               ctrl_ok;

  assign ctrl_wr  = bus_we && (bus_addr == ADDR_W'(OFS_CTRL));
  assign ctrl_ok  = ctrl_wr && !busy;
  assign start    = ctrl_ok && bus_wdata[0];
  assign req_bits = bus_wdata[NUM_OUT:1];

  always_comb begin
    pick = '0;
    for (int i = NUM_OUT - 1; i >= 0; i--) begin
      if (req_bits[i]) pick = NUM_OUT'(1) << i;
    end
  end

  always_comb begin
    gpo_n  = gpo_q;
    csel_n = csel_q;
    tx_n   = tx_q;
    done_n = done_q;
    if (bus_we && (bus_addr == ADDR_W'(OFS_GPO))) gpo_n = bus_wdata[NUM_OUT-1:0];
    if (bus_we && (bus_addr == ADDR_W'(OFS_TX)))  tx_n  = bus_wdata;
    if (ctrl_ok) csel_n = pick;
    if (start)           done_n = 1'b0;
    else if (done_pulse) done_n = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gpo_q  <= '0;
      csel_q <= '0;
      tx_q   <= '0;
      done_q <= 1'b0;
    end else begin
      gpo_q  <= gpo_n;
      csel_q <= csel_n;
      tx_q   <= tx_n;
      done_q <= done_n;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(OFS_GPO):  bus_rdata[NUM_OUT-1:0] = gpo_q;
      ADDR_W'(OFS_CTRL): bus_rdata[NUM_OUT:0]   = {csel_q, busy};
      ADDR_W'(OFS_STAT): bus_rdata[0]           = done_q;
      ADDR_W'(OFS_TX):   bus_rdata              = tx_q;
      ADDR_W'(OFS_RX):   bus_rdata              = rx_byte;
      default:           bus_rdata              = '0;
    endcase
  end

  assign gpo       = gpo_q;
  assign csel      = csel_q;
  assign tx_byte   = tx_q;
  assign done_flag = done_q;
endmodule

// File: rtl/spi_route_pinmux.sv
module spi_route_pinmux #(
  parameter int NUM_OUT = 4
) (
  input  logic [NUM_OUT-1:0] gpo,
  input  logic [NUM_OUT-1:0] csel,
  input  logic               cs_act,
  output logic [NUM_OUT-1:0] pins
);
  for (genvar g = 0; g < NUM_OUT; g++) begin : g_pin
    assign pins[g] = csel[g] ? ~cs_act : gpo[g];
  end
endmodule

// File: rtl/spi_route_master.sv
module spi_route_master #(
  parameter int CLK_DIV = 4,
  parameter int ADDR_W  = 4,
  parameter int DATA_W  = 8,
  parameter int NUM_OUT = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic               spi_miso,
  output logic               spi_mosi,
  output logic               spi_sclk,
  output logic [NUM_OUT-1:0] out_pins
);
  localparam int HALF_CYC = CLK_DIV / 2;

  logic              rst_s1, rst_s2;
  logic              busy, cs_act, tick, done_pulse, start, ctrl_wr, done_flag;
  logic [DATA_W-1:0] rx_byte, tx_byte;
  logic [NUM_OUT-1:0] gpo, csel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1 <= 1'b0;
      rst_s2 <= 1'b0;
    end else begin
      rst_s1 <= 1'b1;
      rst_s2 <= rst_s1;
    end
  end

  spi_route_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NUM_OUT(NUM_OUT)) u_regs (
    .clk(clk), .rst_n(rst_s2), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy),
    .done_pulse(done_pulse), .rx_byte(rx_byte), .gpo(gpo), .csel(csel),
    .tx_byte(tx_byte), .start(start), .ctrl_wr(ctrl_wr), .done_flag(done_flag)
  );

  spi_route_clkdiv #(.HALF_CYC(HALF_CYC)) u_div (
    .clk(clk), .rst_n(rst_s2), .run(busy), .tick(tick)
  );

  spi_route_engine #(.DATA_W(DATA_W)) u_eng (
    .clk(clk), .rst_n(rst_s2), .start(start), .tx_byte(tx_byte),
    .miso(spi_miso), .tick(tick), .busy(busy), .cs_act(cs_act),
    .sclk(spi_sclk), .mosi(spi_mosi), .done_pulse(done_pulse), .rx_byte(rx_byte)
  );

  spi_route_pinmux #(.NUM_OUT(NUM_OUT)) u_mux (
    .gpo(gpo), .csel(csel), .cs_act(cs_act), .pins(out_pins)
  );
endmodule

// File: rtl/spi_route_chk.sv
module spi_route_chk #(
  parameter int NUM_OUT = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               busy,
  input logic               cs_act,
  input logic               start,
  input logic               ctrl_wr,
  input logic               done_flag,
  input logic [NUM_OUT-1:0] csel,
  input logic               spi_sclk,
  input logic               spi_mosi
);
  AST_SEL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(csel)); // R8

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sclk); // R4

  AST_SCLK_INSIDE_CS: assert property (@(posedge clk) disable iff (!rst_n)
    spi_sclk |-> cs_act); // R5

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && busy && !$fell(spi_sclk)) |-> $stable(spi_mosi)); // R3

  AST_DONE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !done_flag); // R6

  AST_BUSY_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ctrl_wr) |=> $stable(csel)); // R10
endmodule

bind spi_route_master spi_route_chk #(.NUM_OUT(NUM_OUT)) u_chk (
  .clk(clk), .rst_n(rst_s2), .busy(busy), .cs_act(cs_act), .start(start),
  .ctrl_wr(ctrl_wr), .done_flag(done_flag), .csel(csel),
  .spi_sclk(spi_sclk), .spi_mosi(spi_mosi)
);

// File: tb/spi_route_master_tb.sv
module spi_route_master_tb;
  localparam int CLK_DIV = 4;
  localparam int HALF    = CLK_DIV / 2;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_we = 1'b0;
  logic [3:0] bus_addr = '0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       spi_miso = 1'b0;
  logic       spi_mosi, spi_sclk;
  logic [3:0] out_pins;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  spi_route_master #(.CLK_DIV(CLK_DIV)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_miso(spi_miso),
    .spi_mosi(spi_mosi), .spi_sclk(spi_sclk), .out_pins(out_pins)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
  endtask

  task automatic do_xfer(input int sel, input logic [7:0] ctrl, input logic [7:0] tx,
                         input logic [7:0] slv, input logic [3:0] gpo_e,
                         input int inj_at, input logic [7:0] inj_d, input string tag);
    int rise_ix[8];
    int nrise = 0, cs_fall = -1, cs_rise = -1, bitidx = 0, viol = 0, pin_bad = 0;
    logic [7:0] cap = '0;
    logic [7:0] rd;
    logic psclk, pmosi, p;
    bus_write(4'd8, tx);
    spi_miso = slv[7];
    bus_write(4'd5, ctrl);
    bus_read(4'd6, rd);
    check(rd[0] == 1'b0, {"R6 status cleared on start ", tag}, rd, 0);
    psclk = spi_sclk; pmosi = spi_mosi;
    for (int i = 0; i < 80; i++) begin
      if (i == inj_at) begin
        bus_we = 1'b1; bus_addr = 4'd5; bus_wdata = inj_d;
      end else begin
        bus_we = 1'b0;
      end
      p = (sel >= 0) ? out_pins[sel] : 1'b1;
      if (cs_fall < 0 && !p) cs_fall = i;
      if (spi_sclk && !psclk) begin
        if (nrise < 8) rise_ix[nrise] = i;
        nrise++;
        cap = {cap[6:0], spi_mosi};
      end
      if (!spi_sclk && psclk) begin
        bitidx++;
        if (bitidx < 8) spi_miso = slv[7 - bitidx];
      end
      if (i > 0 && spi_mosi != pmosi && !(psclk && !spi_sclk)) viol++;
      for (int j = 0; j < 4; j++) begin
        if (j != sel && out_pins[j] != gpo_e[j]) pin_bad++;
      end
      if (cs_fall >= 0 && p && cs_rise < 0) cs_rise = i;
      psclk = spi_sclk; pmosi = spi_mosi;
      @(negedge clk);
    end
    bus_we = 1'b0;
    check(nrise == 8, {"R4 eight rising edges ", tag}, nrise, 8);
    for (int k = 1; k < 8; k++)
      check(rise_ix[k] - rise_ix[k-1] == CLK_DIV, {"R4 sclk period ", tag},
            rise_ix[k] - rise_ix[k-1], CLK_DIV);
    check(cap == tx, {"R3 mosi msb first ", tag}, cap, tx);
    check(viol == 0, {"R3 mosi changes only on falling sclk ", tag}, viol, 0);
    if (sel >= 0) begin
      check(cs_fall == 0, {"R5 select asserts with start ", tag}, cs_fall, 0);
      check(rise_ix[0] - cs_fall == HALF, {"R5 lead time ", tag}, rise_ix[0] - cs_fall, HALF);
      check(cs_rise - rise_ix[7] == CLK_DIV, {"R5 trail time ", tag},
            cs_rise - rise_ix[7], CLK_DIV);
      check(out_pins[sel] == 1'b1, {"R9 select high when idle ", tag}, out_pins[sel], 1);
      check(pin_bad == 0, {"R9 other pins follow output reg ", tag}, pin_bad, 0);
    end else begin
      check(pin_bad == 0, {"R11 no pin claimed ", tag}, pin_bad, 0);
    end
    bus_read(4'd12, rd);
    check(rd == slv, {"R7 receive byte ", tag}, rd, slv);
    bus_read(4'd6, rd);
    check(rd[0] == 1'b1, {"R6 status done ", tag}, rd, 1);
  endtask

  task automatic t_reset();
    logic [7:0] rd;
    check(out_pins == 4'h0, "R1 pins after reset", out_pins, 0);
    check(spi_sclk == 1'b0, "R1 sclk after reset", spi_sclk, 0);
    bus_read(4'd6, rd);
    check(rd == 8'h00, "R1 status after reset", rd, 0);
    bus_read(4'd12, rd);
    check(rd == 8'h00, "R1 rx after reset", rd, 0);
  endtask

  task automatic t_regs();
    logic [7:0] rd;
    bus_write(4'd0, 8'h06);
    check(out_pins == 4'h6, "R2 output reg drives pins", out_pins, 6);
    bus_read(4'd0, rd);
    check(rd == 8'h06, "R2 output reg readback", rd, 6);
    bus_write(4'd8, 8'h5C);
    bus_read(4'd8, rd);
    check(rd == 8'h5C, "R2 tx readback", rd, 8'h5C);
    bus_write(4'd12, 8'hFF);
    bus_read(4'd12, rd);
    check(rd == 8'h00, "R2 rx ignores writes", rd, 0);
  endtask

  task automatic t_basic();
    do_xfer(0, 8'h03, 8'hA5, 8'h3C, 4'h6, -1, 8'h00, "pin0");
  endtask

  task automatic t_pin3_override();
    bus_write(4'd0, 8'h0F);
    do_xfer(3, 8'h11, 8'h81, 8'hE7, 4'hF, -1, 8'h00, "pin3");
    bus_write(4'd0, 8'h00);
    check(out_pins[3] == 1'b1, "R9 output bit ignored on select pin", out_pins[3], 1);
    check(out_pins[2:0] == 3'b000, "R9 unselected pins follow", out_pins[2:0], 0);
  endtask

  task automatic t_priority();
    logic [7:0] rd;
    do_xfer(0, 8'h1B, 8'h3C, 8'h5A, 4'h0, -1, 8'h00, "priority");
    bus_read(4'd5, rd);
    check(rd == 8'h02, "R8 lowest select bit wins", rd, 8'h02);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] rd;
    bus_write(4'd0, 8'h00);
    do_xfer(1, 8'h05, 8'hC3, 8'h96, 4'h0, 10, 8'h11, "busy write");
    bus_read(4'd5, rd);
    check(rd == 8'h04, "R10 selection kept after busy write", rd, 8'h04);
  endtask

  task automatic t_nosel();
    bus_write(4'd0, 8'h09);
    do_xfer(-1, 8'h01, 8'hFF, 8'h00, 4'h9, -1, 8'h00, "nosel");
    check(out_pins == 4'h9, "R11 pins equal output reg", out_pins, 9);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_basic();
    t_pin3_override();
    t_priority();
    t_busy_ignore();
    t_nosel();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule